// File: doc/BRIEF.md
# Register-Format Integer Execute Unit

This block is the execute stage for the register-to-register instruction group of a 32-bit load/store processor. Each cycle it receives an instruction word together with the two source operand values already read from the register file. It decodes the 6-bit function code in the low bits of the word and computes one of the following: a shift, a bitwise logic result, a sum or difference, a signed or unsigned comparison, or a move from the HI/LO pair. The HI/LO values come from a separate multiply/divide unit.

The block also recognises the register-indirect jumps, the system-call trap, the all-zero no-op and any unassigned function code, and reports each of these on a flag. Every output is captured in one register stage. The result, the destination index and the write-enable reach the register-file write port one clock after the inputs are presented.

Fetch, the register file, memory access, overflow traps and delay-slot sequencing are left to neighbouring blocks.

Top module: `rrx_exec_unit`

## Requirements
- R1: The operation is chosen by instruction bits [5:0]. The operand fields are rs=[25:21] and rt=[20:16], the destination is rd=[15:11] and the immediate shift amount is [10:6]. Codes 0 (shift left logical), 2 (shift right logical) and 3 (shift right arithmetic) shift the rt value by that immediate amount.
- R2: Codes 4, 6 and 7 are the variable forms of left logical, right logical and right arithmetic shifts. They shift the rt value by bits [4:0] of the rs value, and the upper rs bits are ignored.
- R3: Right logical shifts fill vacated bits with zero. Right arithmetic shifts fill them with bit 31 of rt. A shift amount of 0 returns rt unchanged.
- R4: Code 32 and code 33 each write the 32-bit wrapped sum rs+rt. Code 35 writes the wrapped difference rs-rt. No overflow is signalled.
- R5: Code 36 writes rs AND rt, code 37 writes rs OR rt, code 38 writes rs XOR rt, and code 39 writes the inverse of (rs OR rt).
- R6: Code 42 writes 1 when rs < rt as two's-complement values and 0 otherwise. Code 43 makes the same comparison on unsigned values.
- R7: Codes 8 and 9 set jump_o and drive jump_target_o with the rs value. Code 8 writes nothing. Code 9 writes pc_i+8 to rd.
- R8: Code 12 sets syscall_o and writes nothing. Code 16 writes hi_i to rd and code 18 writes lo_i to rd.
- R9: Any other function code sets illegal_o and deasserts wr_en_o.
- R10: An instruction word equal to 0 sets nop_o and deasserts wr_en_o.
- R11: When rd is 0, wr_en_o stays low for every operation.
- R12: All outputs change only on the rising clock edge and show the result of the inputs sampled at that edge. While rst is high, every output is cleared to 0 at the clock edge. At most one of jump_o, syscall_o, illegal_o and nop_o is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register selected by rs |
| rt_val_i | input | 32 | Value of the register selected by rt |
| pc_i | input | 32 | Address of this instruction |
| hi_i | input | 32 | Current HI value from the multiply/divide unit |
| lo_i | input | 32 | Current LO value from the multiply/divide unit |
| wr_en_o | output | 1 | Register-file write enable |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Value to write |
| jump_o | output | 1 | Register-indirect jump taken |
| jump_target_o | output | 32 | Jump destination |
| syscall_o | output | 1 | System-call trap requested |
| illegal_o | output | 1 | Unassigned function code |
| nop_o | output | 1 | All-zero no-op seen |

## Verification
The assertions assume that the instruction word and the operand values are stable and known at each rising edge. They also assume that reset is high from time zero for at least one edge, so that no registered output ever holds an unknown value. The bench keeps reset high for several cycles before the first instruction. After that it changes inputs only at the falling edge, and every word it drives is fully defined, including the illegal codes.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

    localparam int XLEN = 32;
    localparam int REGW = 5;

    typedef enum logic [5:0] {
        FN_SLL  = 6'd0,
        FN_SRL  = 6'd2,
        FN_SRA  = 6'd3,
        FN_SLLV = 6'd4,
        FN_SRLV = 6'd6,
        FN_SRAV = 6'd7,
        FN_JR   = 6'd8,
        FN_JALR = 6'd9,
        FN_SYS  = 6'd12,
        FN_MFHI = 6'd16,
        FN_MFLO = 6'd18,
        FN_ADD  = 6'd32,
        FN_ADDU = 6'd33,
        FN_SUBU = 6'd35,
        FN_AND  = 6'd36,
        FN_OR   = 6'd37,
        FN_XOR  = 6'd38,
        FN_NOR  = 6'd39,
        FN_SLT  = 6'd42,
        FN_SLTU = 6'd43
    } func_e;

    typedef enum logic [3:0] {
        OP_SHIFT, OP_ARITH, OP_JUMP, OP_SYS, OP_HI, OP_LO, OP_BAD
    } op_class_e;

    typedef enum logic [1:0] { SH_LEFT, SH_RLOG, SH_RARI } shift_kind_e;

    typedef enum logic [2:0] {
        AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_NOR, AL_SLT, AL_SLTU
    } alu_op_e;

    typedef struct packed {
        op_class_e   cls;
        shift_kind_e sh_kind;
        logic        sh_var;
        alu_op_e     alu_op;
        logic        link;
        logic        writes;
    } dec_t;

    typedef struct packed {
        logic            wr_en;
        logic [REGW-1:0] wr_idx;
        logic [XLEN-1:0] wr_data;
        logic            jump;
        logic [XLEN-1:0] target;
        logic            syscall;
        logic            illegal;
        logic            nop;
    } stage_t;

endpackage

// File: rtl/rrx_decode.sv
module rrx_decode
    import rrx_pkg::*;
(
    input  logic [5:0] fn_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o         = '0;
        dec_o.cls     = OP_BAD;
        dec_o.sh_kind = SH_LEFT;
        dec_o.alu_op  = AL_ADD;
        case (fn_i)
            FN_SLL:  begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_LEFT; dec_o.writes = 1'b1; end
            FN_SRL:  begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_RLOG; dec_o.writes = 1'b1; end
            FN_SRA:  begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_RARI; dec_o.writes = 1'b1; end
            FN_SLLV: begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_LEFT; dec_o.sh_var = 1'b1; dec_o.writes = 1'b1; end
            FN_SRLV: begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_RLOG; dec_o.sh_var = 1'b1; dec_o.writes = 1'b1; end
            FN_SRAV: begin dec_o.cls = OP_SHIFT; dec_o.sh_kind = SH_RARI; dec_o.sh_var = 1'b1; dec_o.writes = 1'b1; end
            FN_JR:   begin dec_o.cls = OP_JUMP; end
            FN_JALR: begin dec_o.cls = OP_JUMP; dec_o.link = 1'b1; dec_o.writes = 1'b1; end
            FN_SYS:  begin dec_o.cls = OP_SYS; end
            FN_MFHI: begin dec_o.cls = OP_HI; dec_o.writes = 1'b1; end
            FN_MFLO: begin dec_o.cls = OP_LO; dec_o.writes = 1'b1; end
            FN_ADD,
            FN_ADDU: begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_ADD;  dec_o.writes = 1'b1; end
            FN_SUBU: begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_SUB;  dec_o.writes = 1'b1; end
            FN_AND:  begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_AND;  dec_o.writes = 1'b1; end
            FN_OR:   begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_OR;   dec_o.writes = 1'b1; end
            FN_XOR:  begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_XOR;  dec_o.writes = 1'b1; end
            FN_NOR:  begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_NOR;  dec_o.writes = 1'b1; end
            FN_SLT:  begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_SLT;  dec_o.writes = 1'b1; end
            FN_SLTU: begin dec_o.cls = OP_ARITH; dec_o.alu_op = AL_SLTU; dec_o.writes = 1'b1; end
            default: begin dec_o.cls = OP_BAD; end
        endcase
    end
endmodule

// File: rtl/rrx_shifter.sv
module rrx_shifter
    import rrx_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val_i,
    input  logic [SHW-1:0] amt_i,
    input  shift_kind_e    kind_i,
    output logic [W-1:0]   res_o
);
    always_comb begin
        case (kind_i)
            SH_LEFT: res_o = val_i << amt_i;
            SH_RLOG: res_o = val_i >> amt_i;
            SH_RARI: res_o = W'($signed(val_i) >>> amt_i);
            default: res_o = val_i;
        endcase
    end

    // R3: a zero shift amount leaves the operand untouched
    always_comb begin
        if (amt_i == '0 && !$isunknown(val_i))
            a_r3_zero_amount: assert (res_o == val_i);
    end
endmodule

// File: rtl/rrx_alu.sv
module rrx_alu
    import rrx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] sum_d;
    logic [W-1:0] diff_d;
    logic         lt_s_d;
    logic         lt_u_d;

    always_comb begin
        sum_d  = a_i + b_i;
        diff_d = a_i - b_i;
        lt_s_d = $signed(a_i) < $signed(b_i);
        lt_u_d = a_i < b_i;
        case (op_i)
            AL_ADD:  res_o = sum_d;
            AL_SUB:  res_o = diff_d;
            AL_AND:  res_o = a_i & b_i;
            AL_OR:   res_o = a_i | b_i;
            AL_XOR:  res_o = a_i ^ b_i;
            AL_NOR:  res_o = ~(a_i | b_i);
            AL_SLT:  res_o = W'(lt_s_d);
            AL_SLTU: res_o = W'(lt_u_d);
            default: res_o = '0;
        endcase
    end

    // R6: comparison results are always 0 or 1
    always_comb begin
        if ((op_i == AL_SLT || op_i == AL_SLTU) && !$isunknown(res_o))
            a_r6_bool_result: assert (res_o[W-1:1] == '0);
    end
endmodule

// File: rtl/rrx_exec_unit.sv
module rrx_exec_unit
    import rrx_pkg::*;
#(
    parameter int XW  = XLEN,
    localparam int SHW = $clog2(XW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     instr_i,
    input  logic [XW-1:0]   rs_val_i,
    input  logic [XW-1:0]   rt_val_i,
    input  logic [XW-1:0]   pc_i,
    input  logic [XW-1:0]   hi_i,
    input  logic [XW-1:0]   lo_i,
    output logic            wr_en_o,
    output logic [REGW-1:0] wr_idx_o,
    output logic [XW-1:0]   wr_data_o,
    output logic            jump_o,
    output logic [XW-1:0]   jump_target_o,
    output logic            syscall_o,
    output logic            illegal_o,
    output logic            nop_o
);
    localparam logic [XW-1:0] LINK_OFS = XW'(8);

    dec_t           dec;
    logic [SHW-1:0] sh_amt_d;
    logic [XW-1:0]  sh_res_d;
    logic [XW-1:0]  alu_res_d;
    logic [REGW-1:0] rd_d;
    logic            is_nop_d;
    stage_t          st_d, st_q;

    rrx_decode u_dec (
        .fn_i  (instr_i[5:0]),
        .dec_o (dec)
    );

    always_comb begin
        sh_amt_d = dec.sh_var ? rs_val_i[SHW-1:0] : SHW'(instr_i[10:6]);
    end

    rrx_shifter #(.W(XW)) u_shift (
        .val_i  (rt_val_i),
        .amt_i  (sh_amt_d),
        .kind_i (dec.sh_kind),
        .res_o  (sh_res_d)
    );

    rrx_alu #(.W(XW)) u_alu (
        .a_i   (rs_val_i),
        .b_i   (rt_val_i),
        .op_i  (dec.alu_op),
        .res_o (alu_res_d)
    );

    always_comb begin
        rd_d     = instr_i[15:11];
        is_nop_d = (instr_i == 32'd0);
        st_d     = '0;
        st_d.wr_idx = rd_d;
        case (dec.cls)
            OP_SHIFT: st_d.wr_data = sh_res_d;
            OP_ARITH: st_d.wr_data = alu_res_d;
            OP_HI:    st_d.wr_data = hi_i;
            OP_LO:    st_d.wr_data = lo_i;
            OP_JUMP:  st_d.wr_data = dec.link ? (pc_i + LINK_OFS) : '0;
            default:  st_d.wr_data = '0;
        endcase
        st_d.jump    = (dec.cls == OP_JUMP);
        st_d.target  = (dec.cls == OP_JUMP) ? rs_val_i : '0;
        st_d.syscall = (dec.cls == OP_SYS);
        st_d.illegal = (dec.cls == OP_BAD);
        st_d.nop     = is_nop_d;
        st_d.wr_en   = dec.writes && !is_nop_d && (rd_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_en_o       = st_q.wr_en;
    assign wr_idx_o      = st_q.wr_idx;
    assign wr_data_o     = st_q.wr_data;
    assign jump_o        = st_q.jump;
    assign jump_target_o = st_q.target;
    assign syscall_o     = st_q.syscall;
    assign illegal_o     = st_q.illegal;
    assign nop_o         = st_q.nop;

    a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !wr_en_o);

    a_r11_zero_dest: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o != '0));

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({jump_o, syscall_o, illegal_o, nop_o}));

    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && jump_o) |-> (jump_target_o == $past(rs_val_i)));

    a_r3_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(instr_i[5:0]) == 6'd3) && ($past(instr_i[15:11]) != 5'd0))
        |-> (wr_data_o[XW-1] == $past(rt_val_i[XW-1])));

    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        nop_o |-> !wr_en_o);
endmodule

// File: tb/rrx_exec_unit_test.sv
module rrx_exec_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0, rs_v = '0, rt_v = '0, pc = '0, hi = '0, lo = '0;
    logic        wr_en, jump, sysc, ill, nop;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data, target;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rrx_exec_unit uut (
        .clk(clk), .rst(rst), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
        .pc_i(pc), .hi_i(hi), .lo_i(lo), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
        .wr_data_o(wr_data), .jump_o(jump), .jump_target_o(target),
        .syscall_o(sysc), .illegal_o(ill), .nop_o(nop)
    );

    function automatic logic [31:0] enc(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic [4:0] sa,
                                        input logic [5:0] fn);
        return {6'd0, s, t, d, sa, fn};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, capture at the rising edge, sample 1 time unit later
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = w; rs_v = a; rt_v = b;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_write(input string req, input logic [4:0] idx, input logic [31:0] data);
        chk(req, "wr_en", {31'd0, wr_en}, 32'd1);
        chk(req, "wr_idx", {27'd0, wr_idx}, {27'd0, idx});
        chk(req, "wr_data", wr_data, data);
    endtask

    task automatic t_reset;
        @(negedge clk);
        instr = enc(5'd1, 5'd2, 5'd3, 5'd0, 6'd33); rs_v = 32'h5; rt_v = 32'h6;
        @(posedge clk); #1;
        chk("R12", "reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R12", "reset data", wr_data, 32'd0);
        chk("R12", "reset flags", {27'd0, jump, sysc, ill, nop, 1'b0}, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        expect_write("R12", 5'd3, 32'hB);
    endtask

    task automatic t_imm_shifts;
        issue(enc(5'd0, 5'd1, 5'd5, 5'd4, 6'd0), 32'hFFFF_FFFF, 32'h0000_0081);
        expect_write("R1", 5'd5, 32'h0000_0810);
        issue(enc(5'd0, 5'd1, 5'd6, 5'd31, 6'd2), 32'h0, 32'h8000_0000);
        expect_write("R3", 5'd6, 32'h0000_0001);
        issue(enc(5'd0, 5'd1, 5'd7, 5'd4, 6'd3), 32'h0, 32'h8000_0000);
        expect_write("R3", 5'd7, 32'hF800_0000);
        issue(enc(5'd0, 5'd1, 5'd7, 5'd0, 6'd3), 32'h0, 32'h8000_0001);
        expect_write("R3", 5'd7, 32'h8000_0001);
    endtask

    task automatic t_var_shifts;
        issue(enc(5'd2, 5'd1, 5'd8, 5'd9, 6'd4), 32'h0000_0023, 32'h1);
        expect_write("R2", 5'd8, 32'h0000_0008);
        issue(enc(5'd2, 5'd1, 5'd8, 5'd0, 6'd6), 32'h0000_0008, 32'hF000_0000);
        expect_write("R2", 5'd8, 32'h00F0_0000);
        issue(enc(5'd2, 5'd1, 5'd8, 5'd0, 6'd7), 32'h0000_0024, 32'hF000_0000);
        expect_write("R2", 5'd8, 32'hFF00_0000);
        issue(enc(5'd2, 5'd1, 5'd8, 5'd0, 6'd7), 32'hFFFF_FFE0, 32'h8000_0000);
        expect_write("R3", 5'd8, 32'h8000_0000);
    endtask

    task automatic t_addsub;
        issue(enc(5'd1, 5'd2, 5'd9, 5'd0, 6'd32), 32'hFFFF_FFFF, 32'h2);
        expect_write("R4", 5'd9, 32'h1);
        chk("R4", "no trap", {31'd0, ill}, 32'd0);
        issue(enc(5'd1, 5'd2, 5'd9, 5'd0, 6'd33), 32'h7FFF_FFFF, 32'h1);
        expect_write("R4", 5'd9, 32'h8000_0000);
        issue(enc(5'd1, 5'd2, 5'd9, 5'd0, 6'd35), 32'h1, 32'h2);
        expect_write("R4", 5'd9, 32'hFFFF_FFFF);
    endtask

    task automatic t_logic;
        issue(enc(5'd1, 5'd2, 5'd10, 5'd0, 6'd36), 32'hF0F0_F0F0, 32'hFF00_FF00);
        expect_write("R5", 5'd10, 32'hF000_F000);
        issue(enc(5'd1, 5'd2, 5'd10, 5'd0, 6'd37), 32'hF0F0_F0F0, 32'hFF00_FF00);
        expect_write("R5", 5'd10, 32'hFFF0_FFF0);
        issue(enc(5'd1, 5'd2, 5'd10, 5'd0, 6'd38), 32'hF0F0_F0F0, 32'hFF00_FF00);
        expect_write("R5", 5'd10, 32'h0FF0_0FF0);
        issue(enc(5'd1, 5'd2, 5'd10, 5'd0, 6'd39), 32'hF0F0_F0F0, 32'hFF00_FF00);
        expect_write("R5", 5'd10, 32'h000F_000F);
    endtask

    task automatic t_compare;
        issue(enc(5'd1, 5'd2, 5'd11, 5'd0, 6'd42), 32'hFFFF_FFFF, 32'h1);
        expect_write("R6", 5'd11, 32'h1);
        issue(enc(5'd1, 5'd2, 5'd11, 5'd0, 6'd43), 32'hFFFF_FFFF, 32'h1);
        expect_write("R6", 5'd11, 32'h0);
        issue(enc(5'd1, 5'd2, 5'd11, 5'd0, 6'd42), 32'h5, 32'h5);
        expect_write("R6", 5'd11, 32'h0);
        issue(enc(5'd1, 5'd2, 5'd11, 5'd0, 6'd43), 32'h1, 32'h8000_0000);
        expect_write("R6", 5'd11, 32'h1);
    endtask

    task automatic t_jumps;
        pc = 32'h0040_0010;
        issue(enc(5'd4, 5'd0, 5'd0, 5'd0, 6'd8), 32'h0040_1000, 32'h0);
        chk("R7", "jr jump", {31'd0, jump}, 32'd1);
        chk("R7", "jr target", target, 32'h0040_1000);
        chk("R7", "jr wr_en", {31'd0, wr_en}, 32'd0);
        issue(enc(5'd4, 5'd0, 5'd31, 5'd0, 6'd9), 32'h0050_2000, 32'h0);
        chk("R7", "jalr jump", {31'd0, jump}, 32'd1);
        chk("R7", "jalr target", target, 32'h0050_2000);
        expect_write("R7", 5'd31, 32'h0040_0018);
    endtask

    task automatic t_sys_hilo;
        hi = 32'h1234_5678; lo = 32'h9ABC_DEF0;
        issue(enc(5'd0, 5'd0, 5'd0, 5'd0, 6'd12), 32'h0, 32'h0);
        chk("R8", "syscall", {31'd0, sysc}, 32'd1);
        chk("R8", "syscall wr_en", {31'd0, wr_en}, 32'd0);
        issue(enc(5'd0, 5'd0, 5'd2, 5'd0, 6'd16), 32'h0, 32'h0);
        expect_write("R8", 5'd2, 32'h1234_5678);
        issue(enc(5'd0, 5'd0, 5'd3, 5'd0, 6'd18), 32'h0, 32'h0);
        expect_write("R8", 5'd3, 32'h9ABC_DEF0);
    endtask

    task automatic t_illegal;
        logic [5:0] codes [3] = '{6'd1, 6'd24, 6'd63};
        foreach (codes[k]) begin
            issue(enc(5'd1, 5'd2, 5'd12, 5'd0, codes[k]), 32'h3, 32'h4);
            chk("R9", "illegal flag", {31'd0, ill}, 32'd1);
            chk("R9", "illegal wr_en", {31'd0, wr_en}, 32'd0);
        end
    endtask

    task automatic t_nop_zero;
        issue(32'h0, 32'h1, 32'h1);
        chk("R10", "nop flag", {31'd0, nop}, 32'd1);
        chk("R10", "nop wr_en", {31'd0, wr_en}, 32'd0);
        issue(enc(5'd0, 5'd1, 5'd0, 5'd2, 6'd0), 32'h0, 32'h1);
        chk("R10", "non-zero word nop", {31'd0, nop}, 32'd0);
        chk("R11", "sll to r0 wr_en", {31'd0, wr_en}, 32'd0);
        issue(enc(5'd1, 5'd2, 5'd0, 5'd0, 6'd33), 32'h7, 32'h8);
        chk("R11", "addu to r0 wr_en", {31'd0, wr_en}, 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_imm_shifts();
        t_var_shifts();
        t_addsub();
        t_logic();
        t_compare();
        t_jumps();
        t_sys_hilo();
        t_illegal();
        t_nop_zero();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule